// File: doc/BRIEF.md
# Chainable Serial Configuration Register

This block holds the configuration of one multi-channel readout chip. It is loaded over a single serial line that is clocked by the front-end clock. A 197-stage shift register accepts one bit per clock while the shift enable is high. Its far end drives an output line to the next chip, so any number of identical chips can be loaded as one long chain. Each chip shifts its own stages and passes the overflow onward.

Shifting never disturbs the live parameters. A separate capture strobe, sampled on the same clock, copies the whole shift register into a shadow register. The channel mask, polarity and calibration settings, pipeline depth, chip identity, threshold, counter limit, readout mode bits and the analog trim fields are all wired directly from that shadow register. A host can therefore stream a new image through the whole chain and then change every chip's parameters in the same cycle with one strobe.

Top module: `cfgsr_top`

## Requirements
- R1: While reset is asserted, and after it is released until the first strobe, every parameter output is 0 and `nbr_out` is 0.
- R2: Image bits are numbered 1 to 197. Bit 197 is sent first and bit 1 last. After a full load, bit n sits in stage n, and stage 197 drives `nbr_out`. Each clock with `shift_en` high moves every stage one place toward `nbr_out` and takes `nbr_in` into stage 1. A bit therefore appears on `nbr_out` after 197 shifting clocks.
- R3: A clock with `shift_en` low changes no stage, whatever `nbr_in` does.
- R4: Shifting without a strobe leaves every parameter output unchanged.
- R5: A clock with `latch_stb` high copies all 197 stages into the shadow register, and the outputs show it after that edge. The remaining field positions are as follows. `fe_polarity` is bit 130. `fe_bandwidth` is bits 131-133. `fe_bias_sel` is bits 140-150. `bias_ratio` is bit 160. `drv_bias` is bit 161. `ramp_dir` is bit 165. `comp_dir` is bit 166. `ramp_trim` is bits 167-174. `drv_res` is bits 191-193. `ramp_ped` is bits 194-197.
- R6: `chan_mask[i]` is image bit i+1 (bits 1-128), and `cal_dir` is bit 129.
- R7: `pipe_depth` is bits 134-139, `chip_id` is bits 152-158, `threshold` is bits 175-182 and `cnt_modulo` is bits 183-190. In every multi-bit field, the lowest bit number is the field's LSB.
- R8: `readout_order` is bit 151, `dps_en` is bit 159, `last_chip` is bit 162, `read_nbr` is bit 163 and `read_all` is bit 164.
- R9: When the strobe and a shift share a clock, the shadow register captures the contents as they were before that shift.
- R10: For chips chained `nbr_out` to `nbr_in`, loading 2×197 bits places the first 197 bits sent in the chip farthest from the source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fe_clk | input | 1 | Front-end clock; shifting and capture happen on its rising edge |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| shift_en | input | 1 | Shift one bit this clock |
| latch_stb | input | 1 | Copy the shift register into the shadow register this clock |
| nbr_in | input | 1 | Serial data from the previous chip or from the host |
| nbr_out | output | 1 | Serial data to the next chip (stage 197) |
| chan_mask | output | 128 | Per-channel mask |
| cal_dir | output | 1 | Calibration charge direction |
| fe_polarity | output | 1 | Front-end polarity select |
| fe_bandwidth | output | 3 | Integrator bandwidth code |
| pipe_depth | output | 6 | Pipeline depth |
| fe_bias_sel | output | 11 | Front-end amplifier current code |
| readout_order | output | 1 | Order of pedestal and signal reads |
| chip_id | output | 7 | Chip identity |
| dps_en | output | 1 | Dynamic pedestal subtraction enable |
| bias_ratio | output | 1 | Comparator and ramp bias ratio select |
| drv_bias | output | 1 | Output driver common-mode select |
| last_chip | output | 1 | Marks the last chip of a chain |
| read_nbr | output | 1 | Read neighbours of hit channels |
| read_all | output | 1 | Read every channel |
| ramp_dir | output | 1 | ADC ramp direction |
| comp_dir | output | 1 | ADC comparator edge direction |
| ramp_trim | output | 8 | ADC ramp slope trim |
| threshold | output | 8 | Sparsification threshold |
| cnt_modulo | output | 8 | ADC counter limit |
| drv_res | output | 3 | Output driver resistor enables |
| ramp_ped | output | 4 | ADC ramp pedestal offset |

## Verification
Shifting and capture can land on the same clock edge. In that case the design must choose between the image before the shift and the image after it. The bench provokes this by loading a complete image and then holding the strobe high during one extra shift clock, so the two images differ in nearly every field. The decoded outputs must match the image before the shift. A second strobe with no shift must then show the image moved by one place with the new bit in stage 1. This proves that the shift really happened on that edge.

// File: rtl/cfgsr_pkg.sv
package cfgsr_pkg;

  localparam int CFG_BITS = 197;
  localparam int NUM_CH   = 128;

  // zero-based stage index = image bit number - 1
  localparam int MASK_LO  = 0;
  localparam int CALDIR_B = 128;
  localparam int POL_B    = 129;
  localparam int BW_LO    = 130;
  localparam int BW_W     = 3;
  localparam int DEPTH_LO = 133;
  localparam int DEPTH_W  = 6;
  localparam int ISEL_LO  = 139;
  localparam int ISEL_W   = 11;
  localparam int ORDER_B  = 150;
  localparam int ID_LO    = 151;
  localparam int ID_W     = 7;
  localparam int DPS_B    = 158;
  localparam int BRAT_B   = 159;
  localparam int DRVB_B   = 160;
  localparam int LAST_B   = 161;
  localparam int RNBR_B   = 162;
  localparam int RALL_B   = 163;
  localparam int RDIR_B   = 164;
  localparam int CDIR_B   = 165;
  localparam int TRIM_LO  = 166;
  localparam int TRIM_W   = 8;
  localparam int THR_LO   = 174;
  localparam int THR_W    = 8;
  localparam int MOD_LO   = 182;
  localparam int MOD_W    = 8;
  localparam int RDRV_LO  = 190;
  localparam int RDRV_W   = 3;
  localparam int PED_LO   = 193;
  localparam int PED_W    = 4;

  typedef struct packed {
    logic [NUM_CH-1:0]   chan_mask;
    logic                cal_dir;
    logic                fe_polarity;
    logic [BW_W-1:0]     bandwidth;
    logic [DEPTH_W-1:0]  pipe_depth;
    logic [ISEL_W-1:0]   bias_sel;
    logic                readout_order;
    logic [ID_W-1:0]     chip_id;
    logic                dps_en;
    logic                bias_ratio;
    logic                drv_bias;
    logic                last_chip;
    logic                read_nbr;
    logic                read_all;
    logic                ramp_dir;
    logic                comp_dir;
    logic [TRIM_W-1:0]   ramp_trim;
    logic [THR_W-1:0]    threshold;
    logic [MOD_W-1:0]    cnt_modulo;
    logic [RDRV_W-1:0]   drv_res;
    logic [PED_W-1:0]    ramp_ped;
  } cfg_fields_t;

endpackage

// File: rtl/cfgsr_rst_sync.sv
module cfgsr_rst_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_nxt;

  always_comb begin
    sync_nxt = {sync_q[SYNC_STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sync_q <= '0;
    else              sync_q <= sync_nxt;
  end

  assign rst_n_sync = sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/cfgsr_chain.sv
module cfgsr_chain #(
  parameter int WIDTH = 197
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             ser_in,
  output logic [WIDTH-1:0] stages,
  output logic             ser_out
);

  logic [WIDTH-1:0] stages_nxt;

  always_comb begin
    stages_nxt = stages;
    if (shift_en) stages_nxt = {stages[WIDTH-2:0], ser_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stages <= '0;
    else if (shift_en) stages <= stages_nxt;
  end

  assign ser_out = stages[WIDTH-1];

  // R2: one shift moves the next-to-last stage onto the output and takes in the serial bit
  p_shift_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (ser_out == $past(stages[WIDTH-2])) && (stages[0] == $past(ser_in)));

  // R3: an idle clock changes no stage
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(stages));

endmodule

// File: rtl/cfgsr_shadow.sv
module cfgsr_shadow #(
  parameter int WIDTH = 197
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [WIDTH-1:0] src,
  output logic [WIDTH-1:0] held
);

  logic [WIDTH-1:0] held_nxt;

  always_comb begin
    held_nxt = held;
    if (capture) held_nxt = src;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       held <= '0;
    else if (capture) held <= held_nxt;
  end

  // R4: without a strobe the parameters stay put
  p_param_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(held));

  // R5 and R9: a strobe takes the shift contents present before that edge
  p_capture_pre_r9: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (held == $past(src)));

endmodule

// File: rtl/cfgsr_decode.sv
module cfgsr_decode
  import cfgsr_pkg::*;
(
  input  logic [CFG_BITS-1:0] img,
  output cfg_fields_t         fields
);

  logic [NUM_CH-1:0] mask_w;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_mask
    assign mask_w[c] = img[MASK_LO + c];
  end

  always_comb begin
    fields.chan_mask     = mask_w;
    fields.cal_dir       = img[CALDIR_B];
    fields.fe_polarity   = img[POL_B];
    fields.bandwidth     = img[BW_LO +: BW_W];
    fields.pipe_depth    = img[DEPTH_LO +: DEPTH_W];
    fields.bias_sel      = img[ISEL_LO +: ISEL_W];
    fields.readout_order = img[ORDER_B];
    fields.chip_id       = img[ID_LO +: ID_W];
    fields.dps_en        = img[DPS_B];
    fields.bias_ratio    = img[BRAT_B];
    fields.drv_bias      = img[DRVB_B];
    fields.last_chip     = img[LAST_B];
    fields.read_nbr      = img[RNBR_B];
    fields.read_all      = img[RALL_B];
    fields.ramp_dir      = img[RDIR_B];
    fields.comp_dir      = img[CDIR_B];
    fields.ramp_trim     = img[TRIM_LO +: TRIM_W];
    fields.threshold     = img[THR_LO +: THR_W];
    fields.cnt_modulo    = img[MOD_LO +: MOD_W];
    fields.drv_res       = img[RDRV_LO +: RDRV_W];
    fields.ramp_ped      = img[PED_LO +: PED_W];
  end

endmodule

// File: rtl/cfgsr_top.sv
module cfgsr_top
  import cfgsr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                fe_clk,
  input  logic                rst_n,
  input  logic                shift_en,
  input  logic                latch_stb,
  input  logic                nbr_in,
  output logic                nbr_out,
  output logic [NUM_CH-1:0]   chan_mask,
  output logic                cal_dir,
  output logic                fe_polarity,
  output logic [BW_W-1:0]     fe_bandwidth,
  output logic [DEPTH_W-1:0]  pipe_depth,
  output logic [ISEL_W-1:0]   fe_bias_sel,
  output logic                readout_order,
  output logic [ID_W-1:0]     chip_id,
  output logic                dps_en,
  output logic                bias_ratio,
  output logic                drv_bias,
  output logic                last_chip,
  output logic                read_nbr,
  output logic                read_all,
  output logic                ramp_dir,
  output logic                comp_dir,
  output logic [TRIM_W-1:0]   ramp_trim,
  output logic [THR_W-1:0]    threshold,
  output logic [MOD_W-1:0]    cnt_modulo,
  output logic [RDRV_W-1:0]   drv_res,
  output logic [PED_W-1:0]    ramp_ped
);

  logic                rst_n_int;
  logic [CFG_BITS-1:0] shift_img;
  logic [CFG_BITS-1:0] live_img;
  cfg_fields_t         fields;

  cfgsr_rst_sync #(.SYNC_STAGES(SYNC_STAGES)) u_rst (
    .clk         (fe_clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_int)
  );

  cfgsr_chain #(.WIDTH(CFG_BITS)) u_chain (
    .clk      (fe_clk),
    .rst_n    (rst_n_int),
    .shift_en (shift_en),
    .ser_in   (nbr_in),
    .stages   (shift_img),
    .ser_out  (nbr_out)
  );

  cfgsr_shadow #(.WIDTH(CFG_BITS)) u_shadow (
    .clk     (fe_clk),
    .rst_n   (rst_n_int),
    .capture (latch_stb),
    .src     (shift_img),
    .held    (live_img)
  );

  cfgsr_decode u_decode (
    .img    (live_img),
    .fields (fields)
  );

  assign chan_mask     = fields.chan_mask;
  assign cal_dir       = fields.cal_dir;
  assign fe_polarity   = fields.fe_polarity;
  assign fe_bandwidth  = fields.bandwidth;
  assign pipe_depth    = fields.pipe_depth;
  assign fe_bias_sel   = fields.bias_sel;
  assign readout_order = fields.readout_order;
  assign chip_id       = fields.chip_id;
  assign dps_en        = fields.dps_en;
  assign bias_ratio    = fields.bias_ratio;
  assign drv_bias      = fields.drv_bias;
  assign last_chip     = fields.last_chip;
  assign read_nbr      = fields.read_nbr;
  assign read_all      = fields.read_all;
  assign ramp_dir      = fields.ramp_dir;
  assign comp_dir      = fields.comp_dir;
  assign ramp_trim     = fields.ramp_trim;
  assign threshold     = fields.threshold;
  assign cnt_modulo    = fields.cnt_modulo;
  assign drv_res       = fields.drv_res;
  assign ramp_ped      = fields.ramp_ped;

endmodule

// File: tb/cfgsr_top_tb_top.sv
module cfgsr_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 100000;

  // table entry: {id7, thr8, mod8, depth6, order, dps, last, rnbr, rall, caldir, seed8}
  localparam logic [42:0] VEC [4] = '{
    {7'h05, 8'h20, 8'hFF, 6'd42, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'hA5},
    {7'h7E, 8'h81, 8'h3C, 6'd01, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h0F},
    {7'h2A, 8'h5A, 8'hC3, 6'd63, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h96},
    {7'h11, 8'hF0, 8'h07, 6'd20, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h3C}
  };

  logic clk;
  logic rst_n;
  logic shift_en;
  logic latch_stb;
  logic nbr_in;
  logic near_out;
  logic far_out;
  logic [196:0] n_obs;
  logic [196:0] f_obs;

  int total;
  int bad;

  cfgsr_top dut_i (
    .fe_clk(clk), .rst_n(rst_n), .shift_en(shift_en), .latch_stb(latch_stb),
    .nbr_in(nbr_in), .nbr_out(near_out),
    .chan_mask(n_obs[196:69]), .cal_dir(n_obs[68]), .fe_polarity(n_obs[67]),
    .fe_bandwidth(n_obs[66:64]), .pipe_depth(n_obs[63:58]), .fe_bias_sel(n_obs[57:47]),
    .readout_order(n_obs[46]), .chip_id(n_obs[45:39]), .dps_en(n_obs[38]),
    .bias_ratio(n_obs[37]), .drv_bias(n_obs[36]), .last_chip(n_obs[35]),
    .read_nbr(n_obs[34]), .read_all(n_obs[33]), .ramp_dir(n_obs[32]),
    .comp_dir(n_obs[31]), .ramp_trim(n_obs[30:23]), .threshold(n_obs[22:15]),
    .cnt_modulo(n_obs[14:7]), .drv_res(n_obs[6:4]), .ramp_ped(n_obs[3:0])
  );

  cfgsr_top far_i (
    .fe_clk(clk), .rst_n(rst_n), .shift_en(shift_en), .latch_stb(latch_stb),
    .nbr_in(near_out), .nbr_out(far_out),
    .chan_mask(f_obs[196:69]), .cal_dir(f_obs[68]), .fe_polarity(f_obs[67]),
    .fe_bandwidth(f_obs[66:64]), .pipe_depth(f_obs[63:58]), .fe_bias_sel(f_obs[57:47]),
    .readout_order(f_obs[46]), .chip_id(f_obs[45:39]), .dps_en(f_obs[38]),
    .bias_ratio(f_obs[37]), .drv_bias(f_obs[36]), .last_chip(f_obs[35]),
    .read_nbr(f_obs[34]), .read_all(f_obs[33]), .ramp_dir(f_obs[32]),
    .comp_dir(f_obs[31]), .ramp_trim(f_obs[30:23]), .threshold(f_obs[22:15]),
    .cnt_modulo(f_obs[14:7]), .drv_res(f_obs[6:4]), .ramp_ped(f_obs[3:0])
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // image index k holds image bit k+1
  function automatic logic [196:0] build_img(input logic [42:0] v);
    logic [196:0] m;
    logic [6:0] id;
    logic [7:0] thr;
    logic [7:0] md;
    logic [5:0] dep;
    id  = v[42:36];
    thr = v[35:28];
    md  = v[27:20];
    dep = v[19:14];
    m = '0;
    m[127:0]   = {16{v[7:0]}};
    m[128]     = v[8];
    m[129]     = ~v[13];
    m[132:130] = dep[2:0];
    m[138:133] = dep;
    m[149:139] = {thr[2:0], md};
    m[150]     = v[13];
    m[157:151] = id;
    m[158]     = v[12];
    m[159]     = v[12] ^ v[11];
    m[160]     = v[10];
    m[161]     = v[11];
    m[162]     = v[10];
    m[163]     = v[9];
    m[164]     = ~v[9];
    m[165]     = v[8];
    m[173:166] = ~thr;
    m[181:174] = thr;
    m[189:182] = md;
    m[192:190] = id[2:0];
    m[196:193] = md[3:0];
    return m;
  endfunction

  // expected output vector in the bench's port-slice order
  function automatic logic [196:0] exp_obs(input logic [196:0] m);
    return {m[127:0], m[128], m[129], m[132:130], m[138:133], m[149:139], m[150],
            m[157:151], m[158], m[159], m[160], m[161], m[162], m[163], m[164],
            m[165], m[173:166], m[181:174], m[189:182], m[192:190], m[196:193]};
  endfunction

  task automatic check(input string req, input logic [196:0] act, input logic [196:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input logic stb);
    nbr_in    = b;
    shift_en  = 1'b1;
    latch_stb = stb;
    @(negedge clk);
    shift_en  = 1'b0;
    latch_stb = 1'b0;
  endtask

  task automatic load(input logic [196:0] m);
    for (int k = 196; k >= 0; k--) send_bit(m[k], 1'b0);
  endtask

  task automatic strobe();
    latch_stb = 1'b1;
    @(negedge clk);
    latch_stb = 1'b0;
  endtask

  initial begin
    repeat (WDOG_CYCLES) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [196:0] img_a;
    logic [196:0] img_b;
    logic [196:0] img_c;
    logic [196:0] img_f;
    logic [196:0] img_n;
    logic nb_hold;
    int sdo_err;
    total = 0;
    bad = 0;
    rst_n = 1'b0;
    shift_en = 1'b0;
    latch_stb = 1'b0;
    nbr_in = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset outputs", n_obs, '0);
    check("R1 reset nbr_out", near_out, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", n_obs, '0);

    // table walk: load, strobe, decode
    img_a = '0;
    for (int i = 0; i < 4; i++) begin
      img_a = build_img(VEC[i]);
      load(img_a);
      strobe();
      check("R5 full image", n_obs, exp_obs(img_a));
      check("R6 chan_mask", n_obs[196:69], {16{VEC[i][7:0]}});
      check("R6 cal_dir", n_obs[68], VEC[i][8]);
      check("R7 pipe_depth", n_obs[63:58], VEC[i][19:14]);
      check("R7 chip_id", n_obs[45:39], VEC[i][42:36]);
      check("R7 threshold", n_obs[22:15], VEC[i][35:28]);
      check("R7 cnt_modulo", n_obs[14:7], VEC[i][27:20]);
      check("R8 mode bits", {n_obs[46], n_obs[38], n_obs[35], n_obs[34], n_obs[33]},
            {VEC[i][13], VEC[i][12], VEC[i][11], VEC[i][10], VEC[i][9]});
    end

    // R4: shifting a new image without strobe leaves outputs
    img_b = build_img(VEC[0]);
    load(img_b);
    check("R4 no strobe keeps params", n_obs, exp_obs(img_a));
    check("R2 nbr_out after load", near_out, img_b[196]);

    // R3: idle clocks with toggling input
    nb_hold = near_out;
    sdo_err = 0;
    for (int k = 0; k < 10; k++) begin
      nbr_in = k[0];
      @(negedge clk);
      if (near_out !== nb_hold) sdo_err++;
    end
    check("R3 nbr_out stable idle", sdo_err, 0);
    strobe();
    check("R3 contents held idle", n_obs, exp_obs(img_b));

    // R2: bits leave in sending order
    sdo_err = 0;
    for (int k = 0; k < 196; k++) begin
      send_bit(1'b0, 1'b0);
      if (near_out !== img_b[195 - k]) sdo_err++;
    end
    check("R2 serial out order", sdo_err, 0);
    send_bit(1'b0, 1'b0);
    check("R2 first filler bit out", near_out, 1'b0);

    // R9: strobe coincident with a shift
    img_c = build_img(VEC[2]);
    load(img_c);
    send_bit(1'b1, 1'b1);
    check("R9 pre-shift captured", n_obs, exp_obs(img_c));
    strobe();
    check("R9 shift took effect", n_obs, exp_obs({img_c[195:0], 1'b1}));

    // R10: two chained chips
    img_f = build_img(VEC[1]);
    img_n = build_img(VEC[3]);
    load(img_f);
    load(img_n);
    strobe();
    check("R10 far chip image", f_obs, exp_obs(img_f));
    check("R10 near chip image", n_obs, exp_obs(img_n));
    check("R10 far chip id", f_obs[45:39], VEC[1][42:36]);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule